// File: doc/BRIEF.md
# System-Space Control Register Decoder

This block sits beside the processor's memory interface and claims the accesses made in the system address space (address space identifier 2). The top four address bits pick a target: a three-bit translation context register, an eight-bit system enable register, a bus error register that always reads zero, the cache tag and cache data diagnostic windows, or a window passed through to an external serial controller. Targets not listed read as zero and ignore writes.

The block also steers supervisor instruction fetches (identifier 9) while the machine is still booting. Boot state is a bit of the enable register rather than a reset pulse. While the not-boot bit is clear, such a fetch raises a ROM select with a word index taken from the low address bits, and address translation is bypassed. Writing the software-reset bit produces a one-cycle reset request, and the bit then clears itself.

Top module: `sysspace_ctl`

## Requirements
- R1: After reset the context is 0, the enable register is 0x00, the soft-reset output is low and read data is zero.
- R2: A write in identifier 2 with addr[31:28]=3 loads the context from wdata[26:24]. A read of that target returns the context in bits [26:24] with every other bit zero.
- R3: A write with addr[31:28]=4 loads the enable register from wdata[7:0], and a read returns it in bits [7:0]. The bit meanings are: 7 not-boot, 5 DVMA enable, 4 cache enable, 2 software reset, 0 diagnostic.
- R4: A write that sets enable bit 2 raises soft_rst_o for exactly the next cycle, and bit 2 then reads back as 0 unless the enable register is written again.
- R5: Reads with addr[31:28]=8 (cache tags) or 9 (cache data) return 0xFFFFFFFF. Writes to them change neither register.
- R6: Reads of the bus error target (addr[31:28]=6) and of any unlisted target return 0. Writes to them change neither register.
- R7: While enable bit 7 is 0, a read with identifier 9 raises rom_sel_o in the same cycle, with rom_idx_o = addr[18:2]. While bit 7 is 1, rom_sel_o stays low.
- R8: A read or write in identifier 2 with addr[31:28]=0xF raises ser_sel_o. ser_chan_a_o equals addr[2] (0 selects channel B, 1 channel A). ser_ctrl_o is high only when the byte mask is 4'b1000.
- R9: For a serial write, ser_we_o is high. ser_wdata_o carries wdata[31:24] for the control register and wdata[15:8] for the data register.
- R10: A serial read returns ser_rdata_i in bits [31:24] for the control register and in bits [15:8] for the data register, with all other bits zero.
- R11: Accesses with any identifier other than 2 change no register, raise no serial select, and read as zero.
- R12: rdata_o updates on the clock edge that ends a read cycle and holds its value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| asi_i | input | 8 | Address space identifier |
| addr_i | input | 32 | Byte address |
| wdata_i | input | 32 | Write data |
| bmask_i | input | 4 | Byte mask, bit 3 covers bits [31:24] |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| ser_rdata_i | input | 8 | Byte returned by the serial controller |
| ctx_o | output | 3 | Context register |
| sysen_o | output | 8 | System enable register |
| soft_rst_o | output | 1 | One-cycle software reset request |
| rdata_o | output | 32 | Registered read data |
| rom_sel_o | output | 1 | Boot fetch served by ROM |
| rom_idx_o | output | 17 | ROM word index |
| ser_sel_o | output | 1 | Serial window access |
| ser_we_o | output | 1 | Serial window write |
| ser_chan_a_o | output | 1 | Channel A selected (else B) |
| ser_ctrl_o | output | 1 | Control register selected (else data) |
| ser_wdata_o | output | 8 | Byte sent to the serial controller |

## Verification
Directed sequences cover fetches in boot state and after the not-boot bit is set, so the ROM steering is checked against the register bit and not against reset. They also cover context and enable writes whose data carries ones outside the fields that are kept, which shows whether the right byte is taken. Serial accesses use high-byte and other masks on both channels to separate control from data routing. Random traffic mixes identifiers 2, 9 and others over every target code, with random data and masks. It catches writes that leak into the wrong target, a wrong read pattern, and a soft-reset bit that fails to clear.

// File: rtl/sysspace_pkg.sv
package sysspace_pkg;

    localparam int EN_W       = 8;
    localparam int EN_NOTBOOT = 7;
    localparam int EN_DVMA    = 5;
    localparam int EN_CACHE   = 4;
    localparam int EN_SWRST   = 2;
    localparam int EN_DIAG    = 0;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTX,
        SEL_SYSEN,
        SEL_BUSERR,
        SEL_CACHE,
        SEL_SERIAL
    } sel_e;

    typedef struct packed {
        sel_e sel;
        logic rd;
        logic wr;
        logic rom_fetch;
        logic ser_ctrl;
        logic ser_chan_a;
    } acc_s;

    function automatic sel_e map_target(input logic [3:0] code);
        case (code)
            4'h3:    return SEL_CTX;
            4'h4:    return SEL_SYSEN;
            4'h6:    return SEL_BUSERR;
            4'h8:    return SEL_CACHE;
            4'h9:    return SEL_CACHE;
            4'hF:    return SEL_SERIAL;
            default: return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/sysspace_decode.sv
module sysspace_decode
    import sysspace_pkg::*;
#(
    parameter int ASI_W     = 8,
    parameter int ADDR_W    = 32,
    parameter int BMASK_W   = 4,
    parameter int SYS_ASI   = 2,
    parameter int FETCH_ASI = 9
) (
    input  logic [ASI_W-1:0]   asi,
    input  logic [3:0]         tgt_code,
    input  logic               chan_bit,
    input  logic [BMASK_W-1:0] bmask,
    input  logic               rd,
    input  logic               wr,
    input  logic               notboot,
    output acc_s               acc
);
    localparam logic [BMASK_W-1:0] HIGH_BYTE = {1'b1, {(BMASK_W-1){1'b0}}};
    localparam logic [ASI_W-1:0]   SYS_CODE  = ASI_W'(SYS_ASI);
    localparam logic [ASI_W-1:0]   FETCH_CODE = ASI_W'(FETCH_ASI);

    always_comb begin
        acc            = '0;
        acc.sel        = (asi == SYS_CODE) ? map_target(tgt_code) : SEL_NONE;
        acc.rd         = rd;
        acc.wr         = wr;
        acc.rom_fetch  = rd && (asi == FETCH_CODE) && !notboot;
        acc.ser_ctrl   = (bmask == HIGH_BYTE);
        acc.ser_chan_a = chan_bit;
    end
endmodule

// File: rtl/sysspace_regs.sv
module sysspace_regs
    import sysspace_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CTX_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_s              acc,
    input  logic [DATA_W-1:0] wdata,
    output logic [CTX_W-1:0]  ctx,
    output logic [EN_W-1:0]   sysen
);
    localparam int CTX_LSB = DATA_W - 8;

    logic ctx_we, en_we;
    assign ctx_we = acc.wr && (acc.sel == SEL_CTX);
    assign en_we  = acc.wr && (acc.sel == SEL_SYSEN);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx <= '0;
        end else if (ctx_we) begin
            ctx <= wdata[CTX_LSB +: CTX_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sysen <= '0;
        end else if (en_we) begin
            sysen <= wdata[EN_W-1:0];
        end else begin
            sysen[EN_SWRST] <= 1'b0;
        end
    end

    logic unused_acc;
    assign unused_acc = ^{acc.rd, acc.rom_fetch, acc.ser_ctrl, acc.ser_chan_a};
endmodule

// File: rtl/sysspace_rdmux.sv
module sysspace_rdmux
    import sysspace_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CTX_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_s              acc,
    input  logic [CTX_W-1:0]  ctx,
    input  logic [EN_W-1:0]   sysen,
    input  logic [7:0]        ser_rdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int HI_LSB  = DATA_W - 8;
    localparam int MID_LSB = 8;

    logic [DATA_W-1:0] rd_val;

    always_comb begin
        rd_val = '0;
        case (acc.sel)
            SEL_CTX:    rd_val[HI_LSB +: CTX_W] = ctx;
            SEL_SYSEN:  rd_val[EN_W-1:0] = sysen;
            SEL_CACHE:  rd_val = '1;
            SEL_SERIAL: begin
                if (acc.ser_ctrl) rd_val[HI_LSB +: 8]  = ser_rdata;
                else              rd_val[MID_LSB +: 8] = ser_rdata;
            end
            default:    rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (acc.rd) begin
            rdata <= rd_val;
        end
    end

    logic unused_acc;
    assign unused_acc = ^{acc.wr, acc.rom_fetch, acc.ser_chan_a};
endmodule

// File: rtl/sysspace_ctl.sv
module sysspace_ctl
    import sysspace_pkg::*;
#(
    parameter int ASI_W     = 8,
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int BMASK_W   = DATA_W / 8,
    parameter int CTX_W     = 3,
    parameter int ROM_AW    = 17,
    parameter int SYS_ASI   = 2,
    parameter int FETCH_ASI = 9
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ASI_W-1:0]   asi_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic [BMASK_W-1:0] bmask_i,
    input  logic               rd_i,
    input  logic               wr_i,
    input  logic [7:0]         ser_rdata_i,
    output logic [CTX_W-1:0]   ctx_o,
    output logic [EN_W-1:0]    sysen_o,
    output logic               soft_rst_o,
    output logic [DATA_W-1:0]  rdata_o,
    output logic               rom_sel_o,
    output logic [ROM_AW-1:0]  rom_idx_o,
    output logic               ser_sel_o,
    output logic               ser_we_o,
    output logic               ser_chan_a_o,
    output logic               ser_ctrl_o,
    output logic [7:0]         ser_wdata_o
);
    localparam int TGT_LSB = ADDR_W - 4;
    localparam int HI_LSB  = DATA_W - 8;

    acc_s acc;

    sysspace_decode #(
        .ASI_W(ASI_W), .ADDR_W(ADDR_W), .BMASK_W(BMASK_W),
        .SYS_ASI(SYS_ASI), .FETCH_ASI(FETCH_ASI)
    ) u_dec (
        .asi      (asi_i),
        .tgt_code (addr_i[TGT_LSB +: 4]),
        .chan_bit (addr_i[2]),
        .bmask    (bmask_i),
        .rd       (rd_i),
        .wr       (wr_i),
        .notboot  (sysen_o[EN_NOTBOOT]),
        .acc      (acc)
    );

    sysspace_regs #(.DATA_W(DATA_W), .CTX_W(CTX_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .acc   (acc),
        .wdata (wdata_i),
        .ctx   (ctx_o),
        .sysen (sysen_o)
    );

    sysspace_rdmux #(.DATA_W(DATA_W), .CTX_W(CTX_W)) u_rd (
        .clk       (clk),
        .rst       (rst),
        .acc       (acc),
        .ctx       (ctx_o),
        .sysen     (sysen_o),
        .ser_rdata (ser_rdata_i),
        .rdata     (rdata_o)
    );

    assign soft_rst_o   = sysen_o[EN_SWRST];
    assign rom_sel_o    = acc.rom_fetch;
    assign rom_idx_o    = addr_i[2 +: ROM_AW];
    assign ser_sel_o    = (acc.sel == SEL_SERIAL) && (rd_i || wr_i);
    assign ser_we_o     = ser_sel_o && wr_i;
    assign ser_chan_a_o = acc.ser_chan_a;
    assign ser_ctrl_o   = acc.ser_ctrl;
    assign ser_wdata_o  = acc.ser_ctrl ? wdata_i[HI_LSB +: 8] : wdata_i[8 +: 8];

    logic unused_bits;
    assign unused_bits = ^{addr_i, wdata_i};
endmodule

// File: rtl/sysspace_chk.sv
module sysspace_chk #(
    parameter int ASI_W  = 8,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CTX_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [ASI_W-1:0]  asi_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic              rd_i,
    input logic              wr_i,
    input logic [CTX_W-1:0]  ctx_o,
    input logic [7:0]        sysen_o,
    input logic              soft_rst_o,
    input logic [DATA_W-1:0] rdata_o,
    input logic              rom_sel_o,
    input logic              ser_sel_o
);
    logic sys_sp, ctx_wr, en_wr;
    assign sys_sp = (asi_i == ASI_W'(2));
    assign ctx_wr = wr_i && sys_sp && (addr_i[ADDR_W-1 -: 4] == 4'h3);
    assign en_wr  = wr_i && sys_sp && (addr_i[ADDR_W-1 -: 4] == 4'h4);

    // R2: context only moves on a context write
    a_r2_ctx_hold: assert property (@(posedge clk) disable iff (rst)
        !ctx_wr |=> $stable(ctx_o));

    // R3: enable bits other than the reset bit hold without an enable write
    a_r3_en_hold: assert property (@(posedge clk) disable iff (rst)
        !en_wr |=> ($stable(sysen_o[7:3]) && $stable(sysen_o[1:0])));

    // R4: reset request follows an enable write carrying bit 2
    a_r4_pulse_src: assert property (@(posedge clk) disable iff (rst)
        !en_wr |=> !soft_rst_o);

    // R4: request never lasts two cycles without a fresh write
    a_r4_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (soft_rst_o && !en_wr) |=> !soft_rst_o);

    // R7: ROM select only for supervisor fetches in boot state
    a_r7_rom_gate: assert property (@(posedge clk) disable iff (rst)
        rom_sel_o |-> (rd_i && asi_i == ASI_W'(9) && !sysen_o[7]));

    // R8: serial select only inside the serial window
    a_r8_ser_window: assert property (@(posedge clk) disable iff (rst)
        ser_sel_o |-> (sys_sp && addr_i[ADDR_W-1 -: 4] == 4'hF));

    // R12: read data holds without a read
    a_r12_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_i |=> $stable(rdata_o));

    logic unused_w;
    assign unused_w = ^wdata_i;
endmodule

bind sysspace_ctl sysspace_chk #(
    .ASI_W(ASI_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTX_W(CTX_W)
) u_chk (
    .clk(clk), .rst(rst), .asi_i(asi_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rd_i(rd_i), .wr_i(wr_i), .ctx_o(ctx_o), .sysen_o(sysen_o),
    .soft_rst_o(soft_rst_o), .rdata_o(rdata_o), .rom_sel_o(rom_sel_o),
    .ser_sel_o(ser_sel_o)
);

// File: tb/tb_sysspace_ctl.sv
`timescale 1ns/1ps
module tb_sysspace_ctl;
    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  asi_i;
    logic [31:0] addr_i;
    logic [31:0] wdata_i;
    logic [3:0]  bmask_i;
    logic        rd_i, wr_i;
    logic [7:0]  ser_rdata_i;
    logic [2:0]  ctx_o;
    logic [7:0]  sysen_o;
    logic        soft_rst_o;
    logic [31:0] rdata_o;
    logic        rom_sel_o;
    logic [16:0] rom_idx_o;
    logic        ser_sel_o, ser_we_o, ser_chan_a_o, ser_ctrl_o;
    logic [7:0]  ser_wdata_o;

    always #4 clk = ~clk;

    sysspace_ctl dut (.*);

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [2:0]  m_ctx;
    logic [7:0]  m_en;
    logic [31:0] m_rd;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [7:0] asi, input logic [31:0] addr,
                                             input logic [3:0] bm, input logic [7:0] sd);
        logic [31:0] v = 32'h0;
        if (asi != 8'd2) return 32'h0;
        case (addr[31:28])
            4'h3: v[26:24] = m_ctx;
            4'h4: v[7:0] = m_en;
            4'h8, 4'h9: v = 32'hFFFF_FFFF;
            4'hF: if (bm == 4'b1000) v[31:24] = sd; else v[15:8] = sd;
            default: v = 32'h0;
        endcase
        return v;
    endfunction

    function automatic string read_req(input logic [7:0] asi, input logic [31:0] addr);
        if (asi != 8'd2) return "R11";
        case (addr[31:28])
            4'h3: return "R2";
            4'h4: return "R3";
            4'h8, 4'h9: return "R5";
            4'hF: return "R10";
            default: return "R6";
        endcase
    endfunction

    task automatic step(input bit rd, input bit wr, input logic [7:0] asi, input logic [31:0] addr,
                        input logic [31:0] wd, input logic [3:0] bm, input logic [7:0] sd);
        bit e_rom, e_ser, ctrl;
        @(negedge clk);
        rd_i = rd; wr_i = wr; asi_i = asi; addr_i = addr;
        wdata_i = wd; bmask_i = bm; ser_rdata_i = sd;
        #1;
        e_rom = rd && asi == 8'd9 && !m_en[7];
        chk(rom_sel_o == e_rom, "R7", 32'(rom_sel_o), 32'(e_rom));
        if (e_rom) chk(rom_idx_o == addr[18:2], "R7", 32'(rom_idx_o), 32'(addr[18:2]));
        e_ser = (asi == 8'd2) && addr[31:28] == 4'hF && (rd || wr);
        chk(ser_sel_o == e_ser, e_ser ? "R8" : "R11", 32'(ser_sel_o), 32'(e_ser));
        if (e_ser) begin
            ctrl = (bm == 4'b1000);
            chk(ser_chan_a_o == addr[2], "R8", 32'(ser_chan_a_o), 32'(addr[2]));
            chk(ser_ctrl_o == ctrl, "R8", 32'(ser_ctrl_o), 32'(ctrl));
            chk(ser_we_o == wr, "R9", 32'(ser_we_o), 32'(wr));
            if (wr) chk(ser_wdata_o == (ctrl ? wd[31:24] : wd[15:8]), "R9",
                        32'(ser_wdata_o), 32'(ctrl ? wd[31:24] : wd[15:8]));
        end
        if (rd) m_rd = exp_read(asi, addr, bm, sd);
        if (wr && asi == 8'd2 && addr[31:28] == 4'h3) m_ctx = wd[26:24];
        if (wr && asi == 8'd2 && addr[31:28] == 4'h4) m_en = wd[7:0];
        else m_en[2] = 1'b0;
        @(posedge clk);
        #1;
        chk(ctx_o == m_ctx, "R2", 32'(ctx_o), 32'(m_ctx));
        chk(sysen_o == m_en, "R3", 32'(sysen_o), 32'(m_en));
        chk(soft_rst_o == m_en[2], "R4", 32'(soft_rst_o), 32'(m_en[2]));
        chk(rdata_o == m_rd, rd ? read_req(asi, addr) : "R12", rdata_o, m_rd);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1957));
        rst = 1; rd_i = 0; wr_i = 0; asi_i = 0; addr_i = 0;
        wdata_i = 0; bmask_i = 0; ser_rdata_i = 0;
        m_ctx = 0; m_en = 0; m_rd = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        chk(ctx_o == 0, "R1", 32'(ctx_o), 0);
        chk(sysen_o == 0, "R1", 32'(sysen_o), 0);
        chk(soft_rst_o == 0, "R1", 32'(soft_rst_o), 0);
        chk(rdata_o == 0, "R1", rdata_o, 0);

        // R7 boot-state fetch
        step(1, 0, 8'd9, 32'h0001_2344, 0, 4'hF, 0);
        // R2 context write with stray bits, then read
        step(0, 1, 8'd2, 32'h3000_0000, 32'hFEFF_FFFF, 4'hF, 0);
        step(1, 0, 8'd2, 32'h3000_0000, 0, 4'hF, 0);
        // R11 other identifier writes are ignored
        step(0, 1, 8'd11, 32'h3000_0000, 32'h0100_0000, 4'hF, 0);
        step(1, 0, 8'd11, 32'h3000_0000, 0, 4'hF, 0);
        // R4 soft reset with not-boot set, then quiet cycles
        step(0, 1, 8'd2, 32'h4000_0000, 32'h0000_00B5, 4'hF, 0);
        step(0, 0, 8'd0, 0, 0, 0, 0);
        step(1, 0, 8'd2, 32'h4000_0000, 0, 4'hF, 0);
        // R7 no ROM steering after boot
        step(1, 0, 8'd9, 32'h0000_0100, 0, 4'hF, 0);
        // R5 cache windows, writes ignored
        step(1, 0, 8'd2, 32'h8000_0010, 0, 4'hF, 0);
        step(0, 1, 8'd2, 32'h9000_0010, 32'h1234_5678, 4'hF, 0);
        step(1, 0, 8'd2, 32'h9000_0010, 0, 4'hF, 0);
        // R6 bus error and unknown target
        step(1, 0, 8'd2, 32'h6000_0000, 0, 4'hF, 0);
        step(0, 1, 8'd2, 32'h5000_0000, 32'hFFFF_FFFF, 4'hF, 0);
        step(1, 0, 8'd2, 32'h5000_0000, 0, 4'hF, 0);
        // R8 R9 R10 serial control and data on both channels
        step(0, 1, 8'd2, 32'hF000_0004, 32'hA55A_C33C, 4'b1000, 0);
        step(0, 1, 8'd2, 32'hF000_0000, 32'hA55A_C33C, 4'b0011, 0);
        step(1, 0, 8'd2, 32'hF000_0000, 0, 4'b1000, 8'h6E);
        step(1, 0, 8'd2, 32'hF000_0004, 0, 4'b1100, 8'h91);
        // R12 hold across idle
        step(0, 0, 8'd2, 32'h8000_0000, 0, 4'hF, 0);
        // back to boot state
        step(0, 1, 8'd2, 32'h4000_0000, 32'h0000_0011, 4'hF, 0);
        step(1, 0, 8'd9, 32'h0007_FFFC, 0, 4'hF, 0);

        for (int i = 0; i < 3000; i++) begin
            logic [7:0]  a;
            logic [31:0] ad;
            logic [3:0]  bm;
            int pick = $urandom_range(0, 9);
            bit r = $urandom_range(0, 1);
            a  = (pick < 6) ? 8'd2 : (pick < 8) ? 8'd9 : 8'($urandom_range(0, 15));
            ad = $urandom;
            bm = ($urandom_range(0, 2) == 0) ? 4'b1000 : 4'($urandom);
            if ($urandom_range(0, 3) == 0) ad[31:28] = 4'h4;
            step(r, !r && $urandom_range(0, 3) != 0, a, ad, $urandom, bm, 8'($urandom));
        end
        finish_run();
    end
endmodule